// File: doc/BRIEF.md
# Serial Thermometer Reader with Seven-Segment Readout

This block runs a three-wire serial thermometer link on its own and presents the result in two forms. After reset it sends a single start-conversion command. From then on it sends a read command once per conversion interval and shifts in a 12-bit two's-complement reading. The reading has 1/16 °C per LSB. The block turns the reading into a whole-degree value and one tenths digit. Readings with the sign bit set are shown as zero. The whole-degree value goes to an 8-bit host input register. The digits drive a four-digit, time-multiplexed, common-anode seven-segment display.

The link controller is a state machine with these states:

- `LINK_IDLE`: one cycle after reset.
- `LINK_SELECT`: select raised, one bit time of setup.
- `LINK_CMD`: eight command bits, LSB first.
- `LINK_TURN`: one bit time with the data line released.
- `LINK_RDATA`: twelve data bits, LSB first.
- `LINK_DESEL`: one bit time of hold before select drops.
- `LINK_WAIT`: select low for the conversion interval.

The transitions are:

- `LINK_IDLE` goes to `LINK_SELECT`.
- `LINK_SELECT` goes to `LINK_CMD`.
- `LINK_CMD` goes to `LINK_TURN` for a read, and straight to `LINK_DESEL` for the start command.
- `LINK_TURN` goes to `LINK_RDATA`.
- `LINK_RDATA` goes to `LINK_DESEL`.
- `LINK_DESEL` goes to `LINK_WAIT`.
- `LINK_WAIT` goes to `LINK_SELECT`.

The serial clock idles high. Within each bit it is low for the first `HALF_CYCLES` clocks and high for the next `HALF_CYCLES` clocks. Outgoing data changes on the falling edge. Incoming data is sampled on the rising edge.

Top module: `temp_reader_top`

## Requirements
- R1: During and right after reset, `sens_sel` is 0, `sens_sclk` is 1, `sens_dq_oe` is 0 and `host_temp` is 0. The display then shows "0.0": digit 1 shows 0 with its point lit, digit 0 shows 0, and digits 2 and 3 are dark. Whenever `sens_sel` is 0, `sens_sclk` is 1.
- R2: The first transaction after reset carries command 8'hEE and has no data phase. Every later transaction carries command 8'hAA followed by exactly 12 data bits.
- R3: Command bits are driven LSB first while `sens_dq_oe` is 1. They change only while `sens_sclk` is low, so they are stable across each rising edge.
- R4: Data bits are sampled on rising `sens_sclk` edges, LSB first, while `sens_dq_oe` is 0.
- R5: Between the end of one transaction and the start of the next, `sens_sel` stays low for exactly `WAIT_CYCLES` clocks.
- R6: For a reading with bit 11 = 0, `host_temp` becomes reading[11:4] two clocks after `sens_sel` falls. `host_temp` changes at no other time.
- R7: The tenths digit (digit 0) shows (reading[3:0] × 10) >> 4.
- R8: A reading with bit 11 = 1 gives `host_temp` = 0 and a display of "0.0".
- R9: Exactly one bit of `dig_en_n` is low at any time (active low). The digits rotate 0, 1, 2, 3, 0, and each stays on for `MUX_CYCLES` clocks.
- R10: Segments are active low, with `seg_n` = ~{g,f,e,d,c,b,a}. The patterns for digits 0–9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. `dp_n` is low only while digit 1 (the units digit) is enabled.
- R11: Digit 3 shows hundreds and digit 2 shows tens of the whole-degree value. Digit 3 is dark when hundreds is 0. Digit 2 is dark when both hundreds and tens are 0. A dark digit has `seg_n` = 7'h7F.
- R12: `sens_dq_oe` is 1 only during the command phase, so the data line is released whenever `sens_sel` is low and during the data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_sel | output | 1 | Sensor select, high during a transaction |
| sens_sclk | output | 1 | Serial clock to the sensor, idles high |
| sens_dq_o | output | 1 | Data driven toward the sensor |
| sens_dq_oe | output | 1 | Output enable for the shared data line |
| sens_dq_i | input | 1 | Data received from the sensor |
| host_temp | output | 8 | Whole-degree temperature for the host input register |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dp_n | output | 1 | Active-low decimal point |
| dig_en_n | output | 4 | Active-low digit enables, bit 0 = tenths |

## Verification
A corrupted link state shows up in the next transaction. It appears as a wrong command byte, a wrong number of data bits, or a wrong gap between transactions. The sensor model catches these within one transaction, about a hundred clocks at the bench settings. A wrong shift or conversion shows up on `host_temp` and on the digits two clocks after select drops. A stuck or skipped multiplex index breaks the digit rotation within one display period. The sweep covers every whole-degree value, every fraction and several negative codes.

// File: rtl/temp_reader_pkg.sv
package temp_reader_pkg;

    typedef enum logic [2:0] {
        LINK_IDLE,
        LINK_SELECT,
        LINK_CMD,
        LINK_TURN,
        LINK_RDATA,
        LINK_DESEL,
        LINK_WAIT
    } link_state_t;

    typedef struct packed {
        logic [3:0] hund;
        logic [3:0] tens;
        logic [3:0] ones;
        logic [3:0] tenth;
        logic       blank_hund;
        logic       blank_tens;
    } temp_digits_t;

    // segment pattern, bit order {g,f,e,d,c,b,a}, active high
    function automatic logic [6:0] seg_pattern(input logic [3:0] d);
        logic [6:0] p;
        case (d)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/temp_link.sv
module temp_link
    import temp_reader_pkg::*;
#(
    parameter int HALF_CYCLES = 50,
    parameter int WAIT_CYCLES = 75_000_000,
    parameter int RAW_W       = 12,
    parameter int CMD_W       = 8,
    parameter logic [CMD_W-1:0] CMD_START = 'hEE,
    parameter logic [CMD_W-1:0] CMD_READ  = 'hAA
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sel,
    output logic             sclk,
    output logic             dq_o,
    output logic             dq_oe,
    input  logic             dq_i,
    output logic [RAW_W-1:0] result,
    output logic             result_valid
);

    localparam int BIT_CYC = 2 * HALF_CYCLES;
    localparam int PH_W    = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam int BIT_MAX = (RAW_W > CMD_W) ? RAW_W : CMD_W;
    localparam int BC_W    = $clog2(BIT_MAX + 1);
    localparam int WAIT_W  = $clog2(WAIT_CYCLES + 1);

    link_state_t       state_q, state_d;
    logic [PH_W-1:0]   ph_cnt;
    logic [BC_W-1:0]   bit_cnt;
    logic [WAIT_W-1:0] wait_cnt;
    logic [CMD_W-1:0]  cmd_sh;
    logic [RAW_W-1:0]  data_sh;
    logic              is_read;
    logic              phase_end;
    logic              sample_now;

    assign phase_end  = (ph_cnt == PH_W'(BIT_CYC - 1));
    assign sample_now = (state_q == LINK_RDATA) && (ph_cnt == PH_W'(HALF_CYCLES));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_IDLE:   state_d = LINK_SELECT;
            LINK_SELECT: if (phase_end) state_d = LINK_CMD;
            LINK_CMD:
                if (phase_end && bit_cnt == BC_W'(CMD_W - 1))
                    state_d = is_read ? LINK_TURN : LINK_DESEL;
            LINK_TURN:   if (phase_end) state_d = LINK_RDATA;
            LINK_RDATA:
                if (phase_end && bit_cnt == BC_W'(RAW_W - 1))
                    state_d = LINK_DESEL;
            LINK_DESEL:  if (phase_end) state_d = LINK_WAIT;
            LINK_WAIT:
                if (wait_cnt == WAIT_W'(WAIT_CYCLES - 1))
                    state_d = LINK_SELECT;
            default:     state_d = LINK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_IDLE;
        else        state_q <= state_d;
    end

    // timing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt   <= '0;
            bit_cnt  <= '0;
            wait_cnt <= '0;
        end else begin
            if (state_d != state_q || phase_end ||
                state_q == LINK_WAIT || state_q == LINK_IDLE)
                ph_cnt <= '0;
            else
                ph_cnt <= ph_cnt + 1'b1;

            if (state_d != state_q)
                bit_cnt <= '0;
            else if (phase_end && (state_q == LINK_CMD || state_q == LINK_RDATA))
                bit_cnt <= bit_cnt + 1'b1;

            if (state_q == LINK_WAIT && state_d == LINK_WAIT)
                wait_cnt <= wait_cnt + 1'b1;
            else
                wait_cnt <= '0;
        end
    end

    // shift registers and result hand-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sh       <= '0;
            data_sh      <= '0;
            is_read      <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            if (state_d == LINK_SELECT && state_q != LINK_SELECT)
                cmd_sh <= is_read ? CMD_READ : CMD_START;
            else if (state_q == LINK_CMD && phase_end)
                cmd_sh <= {1'b0, cmd_sh[CMD_W-1:1]};

            if (sample_now)
                data_sh <= {dq_i, data_sh[RAW_W-1:1]};

            result_valid <= 1'b0;
            if (state_q == LINK_DESEL && phase_end) begin
                is_read <= 1'b1;
                if (is_read) begin
                    result       <= data_sh;
                    result_valid <= 1'b1;
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        sel   = 1'b0;
        sclk  = 1'b1;
        dq_o  = 1'b0;
        dq_oe = 1'b0;
        unique case (state_q)
            LINK_IDLE, LINK_WAIT: ;
            LINK_SELECT, LINK_TURN, LINK_DESEL: sel = 1'b1;
            LINK_CMD: begin
                sel   = 1'b1;
                sclk  = (ph_cnt >= PH_W'(HALF_CYCLES));
                dq_o  = cmd_sh[0];
                dq_oe = 1'b1;
            end
            LINK_RDATA: begin
                sel  = 1'b1;
                sclk = (ph_cnt >= PH_W'(HALF_CYCLES));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/temp_convert.sv
module temp_convert
    import temp_reader_pkg::*;
#(
    parameter int RAW_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RAW_W-1:0]       raw,
    input  logic                   raw_valid,
    output logic [RAW_W-FRAC_W-1:0] host_temp,
    output temp_digits_t           digits
);

    localparam int INT_W = RAW_W - FRAC_W;
    localparam int SCR_W = INT_W + 12;

    logic [INT_W-1:0]    int_part;
    logic [FRAC_W+3:0]   frac_x10;
    logic [3:0]          tenth;
    logic [SCR_W-1:0]    bcd;

    // shift-and-add-3 binary to BCD, three digits
    function automatic logic [SCR_W-1:0] to_bcd(input logic [INT_W-1:0] b);
        logic [SCR_W-1:0] s;
        s = {12'd0, b};
        for (int i = 0; i < INT_W; i++) begin
            for (int d = 0; d < 3; d++) begin
                if (s[INT_W + 4*d +: 4] >= 4'd5)
                    s[INT_W + 4*d +: 4] = s[INT_W + 4*d +: 4] + 4'd3;
            end
            s = s << 1;
        end
        return s;
    endfunction

    always_comb begin
        if (raw[RAW_W-1]) begin
            int_part = '0;
            frac_x10 = '0;
        end else begin
            int_part = raw[RAW_W-1:FRAC_W];
            frac_x10 = (FRAC_W+4)'(raw[FRAC_W-1:0]) * (FRAC_W+4)'(10);
        end
        tenth = 4'(frac_x10 >> FRAC_W);
        bcd   = to_bcd(int_part);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_temp <= '0;
            digits    <= '{hund: 4'd0, tens: 4'd0, ones: 4'd0, tenth: 4'd0,
                           blank_hund: 1'b1, blank_tens: 1'b1};
        end else if (raw_valid) begin
            host_temp         <= int_part;
            digits.hund       <= bcd[INT_W+8 +: 4];
            digits.tens       <= bcd[INT_W+4 +: 4];
            digits.ones       <= bcd[INT_W   +: 4];
            digits.tenth      <= tenth;
            digits.blank_hund <= (bcd[INT_W+8 +: 4] == 4'd0);
            digits.blank_tens <= (bcd[INT_W+4 +: 8] == 8'd0);
        end
    end

endmodule

// File: rtl/temp_display.sv
module temp_display
    import temp_reader_pkg::*;
#(
    parameter int MUX_CYCLES = 100_000,
    parameter int NUM_DIG    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  temp_digits_t       digits,
    output logic [6:0]         seg_n,
    output logic               dp_n,
    output logic [NUM_DIG-1:0] dig_en_n
);

    localparam int MC_W  = (MUX_CYCLES > 1) ? $clog2(MUX_CYCLES) : 1;
    localparam int IDX_W = $clog2(NUM_DIG);

    logic [MC_W-1:0]  mux_cnt;
    logic [IDX_W-1:0] idx;
    logic [6:0]       pat;
    logic             dp_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_cnt <= '0;
            idx     <= '0;
        end else if (mux_cnt == MC_W'(MUX_CYCLES - 1)) begin
            mux_cnt <= '0;
            idx     <= (idx == IDX_W'(NUM_DIG - 1)) ? '0 : idx + 1'b1;
        end else begin
            mux_cnt <= mux_cnt + 1'b1;
        end
    end

    always_comb begin
        pat   = 7'h00;
        dp_on = 1'b0;
        case (idx)
            IDX_W'(0): pat = seg_pattern(digits.tenth);
            IDX_W'(1): begin
                pat   = seg_pattern(digits.ones);
                dp_on = 1'b1;
            end
            IDX_W'(2): pat = digits.blank_tens ? 7'h00 : seg_pattern(digits.tens);
            IDX_W'(3): pat = digits.blank_hund ? 7'h00 : seg_pattern(digits.hund);
            default:   pat = 7'h00;
        endcase
        seg_n = ~pat;
        dp_n  = ~dp_on;
    end

    for (genvar k = 0; k < NUM_DIG; k++) begin : g_en
        assign dig_en_n[k] = (idx != IDX_W'(k));
    end

endmodule

// File: rtl/temp_reader_top.sv
module temp_reader_top
    import temp_reader_pkg::*;
#(
    parameter int HALF_CYCLES = 50,
    parameter int WAIT_CYCLES = 75_000_000,
    parameter int MUX_CYCLES  = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       sens_sel,
    output logic       sens_sclk,
    output logic       sens_dq_o,
    output logic       sens_dq_oe,
    input  logic       sens_dq_i,
    output logic [7:0] host_temp,
    output logic [6:0] seg_n,
    output logic       dp_n,
    output logic [3:0] dig_en_n
);

    localparam int RAW_W  = 12;
    localparam int FRAC_W = 4;

    logic [RAW_W-1:0] raw;
    logic             raw_valid;
    temp_digits_t     digits;

    temp_link #(
        .HALF_CYCLES (HALF_CYCLES),
        .WAIT_CYCLES (WAIT_CYCLES),
        .RAW_W       (RAW_W),
        .CMD_W       (8),
        .CMD_START   (8'hEE),
        .CMD_READ    (8'hAA)
    ) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sens_sel),
        .sclk         (sens_sclk),
        .dq_o         (sens_dq_o),
        .dq_oe        (sens_dq_oe),
        .dq_i         (sens_dq_i),
        .result       (raw),
        .result_valid (raw_valid)
    );

    temp_convert #(
        .RAW_W  (RAW_W),
        .FRAC_W (FRAC_W)
    ) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (raw),
        .raw_valid (raw_valid),
        .host_temp (host_temp),
        .digits    (digits)
    );

    temp_display #(
        .MUX_CYCLES (MUX_CYCLES),
        .NUM_DIG    (4)
    ) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .digits   (digits),
        .seg_n    (seg_n),
        .dp_n     (dp_n),
        .dig_en_n (dig_en_n)
    );

endmodule

// File: rtl/temp_reader_chk.sv
module temp_reader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sens_sel,
    input logic       sens_sclk,
    input logic       sens_dq_o,
    input logic       sens_dq_oe,
    input logic [7:0] host_temp,
    input logic       dp_n,
    input logic [3:0] dig_en_n
);

    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sens_sel |-> sens_sclk);

    // R12
    dq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sens_dq_oe |-> sens_sel);

    // R3
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sens_dq_oe && $past(sens_dq_oe) && sens_sclk && $past(sens_sclk))
        |-> $stable(sens_dq_o));

    // R6
    host_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_temp) |-> (!sens_sel && !$past(sens_sel)));

    // R9
    digit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dig_en_n) == 1);

    // R10
    dp_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_n |-> !dig_en_n[1]);

endmodule

bind temp_reader_top temp_reader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sens_sel   (sens_sel),
    .sens_sclk  (sens_sclk),
    .sens_dq_o  (sens_dq_o),
    .sens_dq_oe (sens_dq_oe),
    .host_temp  (host_temp),
    .dp_n       (dp_n),
    .dig_en_n   (dig_en_n)
);

// File: tb/temp_reader_top_tb.sv
`timescale 1ns/1ps
module temp_reader_top_tb;

    localparam int HALF = 2;
    localparam int WAIT = 40;
    localparam int MUX  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sens_sel, sens_sclk, sens_dq_o, sens_dq_oe;
    logic       sens_dq_i = 1'b0;
    logic [7:0] host_temp;
    logic [6:0] seg_n;
    logic       dp_n;
    logic [3:0] dig_en_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [11:0] resp = '0;
    int          rd_count = 0;

    always #2 clk = ~clk;

    temp_reader_top #(
        .HALF_CYCLES (HALF),
        .WAIT_CYCLES (WAIT),
        .MUX_CYCLES  (MUX)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sens_sel   (sens_sel),
        .sens_sclk  (sens_sclk),
        .sens_dq_o  (sens_dq_o),
        .sens_dq_oe (sens_dq_oe),
        .sens_dq_i  (sens_dq_i),
        .host_temp  (host_temp),
        .seg_n      (seg_n),
        .dp_n       (dp_n),
        .dig_en_n   (dig_en_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    // sensor model, evaluated away from the active edge
    logic       prev_sclk = 1'b1, prev_sel = 1'b0;
    logic [7:0] cmd_bits = '0;
    int cmd_n = 0, fall_n = 0, low_run = 0, txn_n = 0;
    bit oe_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sclk = 1'b1; prev_sel = 1'b0;
            cmd_n = 0; fall_n = 0; low_run = 0; txn_n = 0; oe_bad = 1'b0;
        end else begin
            if (sens_sel) begin
                if (!prev_sel) begin
                    // R5: select low time between transactions
                    if (txn_n > 0)
                        chk(low_run == WAIT, "R5", "select low gap", low_run, WAIT);
                    cmd_n = 0; fall_n = 0; cmd_bits = '0;
                end
                if (sens_sclk && !prev_sclk && sens_dq_oe && cmd_n < 8) begin
                    cmd_bits[cmd_n] = sens_dq_o;
                    cmd_n++;
                end
                if (!sens_sclk && prev_sclk && !sens_dq_oe) begin
                    // R4: present next bit after falling edge, LSB first
                    if (fall_n < 12) sens_dq_i = resp[fall_n];
                    fall_n++;
                end
            end else begin
                if (sens_dq_oe) oe_bad = 1'b1;
                if (prev_sel) begin
                    if (txn_n == 0) begin
                        chk(cmd_bits == 8'hEE, "R2 R3", "start command", cmd_bits, 8'hEE);
                        chk(fall_n == 0, "R2", "start data bits", fall_n, 0);
                    end else begin
                        chk(cmd_bits == 8'hAA, "R2 R3", "read command", cmd_bits, 8'hAA);
                        chk(fall_n == 12, "R2", "read data bits", fall_n, 12);
                    end
                    // R12
                    chk(!oe_bad, "R12", "data line released while deselected", oe_bad, 0);
                    if (fall_n == 12) rd_count++;
                    txn_n++;
                    low_run = 0;
                end
                low_run++;
            end
            prev_sclk = sens_sclk;
            prev_sel  = sens_sel;
        end
    end

    task automatic check_display(input logic [11:0] v);
        int ip, t, h, te, o;
        ip = v[11] ? 0 : int'(v[11:4]);
        t  = v[11] ? 0 : (int'(v[3:0]) * 10) / 16;
        h  = ip / 100;
        te = (ip / 10) % 10;
        o  = ip % 10;
        for (int k = 0; k < 4; k++) begin
            logic [6:0] exp_seg;
            logic       exp_dp;
            while (dig_en_n != ~(4'b0001 << k)) @(negedge clk);
            exp_dp = (k != 1);
            case (k)
                0: exp_seg = ~pat(t);
                1: exp_seg = ~pat(o);
                2: exp_seg = (h == 0 && te == 0) ? 7'h7F : ~pat(te);
                default: exp_seg = (h == 0) ? 7'h7F : ~pat(h);
            endcase
            case (k)
                0: chk(seg_n == exp_seg, v[11] ? "R8" : "R7", "tenths segments", seg_n, exp_seg);
                1: chk(seg_n == exp_seg, "R10", "units segments", seg_n, exp_seg);
                default: chk(seg_n == exp_seg, "R11", "upper digit segments", seg_n, exp_seg);
            endcase
            chk(dp_n == exp_dp, "R10", "decimal point", dp_n, exp_dp);
        end
    endtask

    task automatic run_one(input logic [11:0] v);
        int target;
        int exp_int;
        resp   = v;
        target = rd_count + 1;
        while (rd_count < target) @(negedge clk);
        repeat (4) @(negedge clk);
        exp_int = v[11] ? 0 : int'(v[11:4]);
        chk(host_temp == 8'(exp_int), v[11] ? "R8" : "R4 R6", "host temperature",
            host_temp, exp_int);
        check_display(v);
    endtask

    initial begin
        logic [3:0] d0, d1;
        int n;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(sens_sel == 1'b0, "R1", "select in reset", sens_sel, 0);
        chk(sens_sclk == 1'b1, "R1", "sclk in reset", sens_sclk, 1);
        chk(sens_dq_oe == 1'b0, "R1", "oe in reset", sens_dq_oe, 0);
        chk(host_temp == 8'd0, "R1", "host in reset", host_temp, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_display(12'h000);

        // R9: dwell per digit
        d0 = dig_en_n;
        while (dig_en_n == d0) @(negedge clk);
        d1 = dig_en_n;
        n = 0;
        while (dig_en_n == d1) begin n++; @(negedge clk); end
        chk(n == MUX, "R9", "digit dwell", n, MUX);
        chk(dig_en_n == {d1[2:0], d1[3]}, "R9", "digit order", dig_en_n, {d1[2:0], d1[3]});

        // sweep every whole-degree value with varied fractions
        for (int i = 0; i < 128; i++)
            run_one({i[7:0], i[3:0] ^ i[7:4]});
        // every fraction at a fixed integer (R7)
        for (int f = 0; f < 16; f++)
            run_one({8'd25, f[3:0]});
        // negative codes clamp (R8), then largest positive
        run_one(12'h800);
        run_one(12'hFFF);
        run_one(12'hC93);
        run_one(12'h7FF);
        run_one(12'h009);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", rd_count, 149);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule